// File: doc/BRIEF.md
# Pipeline Stall Statistics Collector

This block sits beside a processor pipeline and turns its stall line into performance counters. Every unbroken run of stalled cycles is one episode. The block tags each episode with a cause: a dependency stall, meaning a data or control hazard, or a memory interlock stall, meaning a load or store held in the memory stage by memory latency. It measures how many cycles the episode lasts. When the episode ends, the block adds one to a histogram bin chosen by that length, in a histogram kept separately for each cause. It also keeps a running total of stalled cycles for each cause.

Software, or a debug agent, reads any counter through a combinational address/data port. A one-cycle clear strobe resets every counter. Because the histogram separates lengths up to fifteen cycles, short hazard stalls stay apart from long memory-latency stalls, and a reader can tell cache hits from misses by their episode lengths.

Top module: `stall_stats`

## Requirements
- R1: After reset, every readable counter reads zero.
- R2: An episode is a maximal run of cycles with `stall_i` high, and its length is the number of those cycles. The episode is recorded on the first cycle `stall_i` is low. The bin whose index equals the length goes up by one, and the new value can be read right after that cycle's clock edge.
- R3: An episode of 15 or more cycles is recorded in bin 15. Bin 0 is never incremented.
- R4: The cause of an episode is the value of `stall_mem_i` on the episode's first cycle (0 = dependency, 1 = memory interlock). Later changes of `stall_mem_i` during the episode have no effect.
- R5: Each stalled cycle adds one to the stalled-cycle total of the episode's cause. The new total can be read right after that cycle's clock edge.
- R6: Dependency episodes and interlock episodes go into separate 16-bin histograms.
- R7: Every counter saturates at 2^CNT_W-1 and never wraps.
- R8: While `clear_i` is high, every counter and bin becomes zero at the next edge, and any episode in progress is dropped without being recorded. A stalled cycle during the clear is not counted. If stall stays high afterwards, a new episode starts on the next stalled cycle and takes its cause from that cycle.
- R9: The read map is as follows. Address 0..15 is dependency bin 0..15. Address 16..31 is interlock bin 0..15. Address 32 is the dependency cycle total and address 33 is the interlock cycle total. Every other address reads zero. `rd_data_o` follows `rd_addr_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Synchronous clear of all counters |
| stall_i | input | 1 | Pipeline stalled this cycle |
| stall_mem_i | input | 1 | Stall cause: 1 = memory interlock, 0 = dependency |
| rd_addr_i | input | 6 | Counter read address |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
On every cycle, the assertions check these properties:
- A tracked episode always has a nonzero length, capped at the last bin.
- The captured cause holds for the whole episode.
- An episode is only recorded right after a stalled cycle.
- Bin 0 stays zero.
- Cycle totals never decrease except through a clear.
- A clear empties the totals.

The exact bin an episode lands in, and the separation by cause, can only be shown by the bench scenarios, which compare every address against a behavioural model each cycle. The same holds for saturation values, the dropping of an episode cut by a clear, and the zero reads outside the map.

// File: rtl/stall_stats_pkg.sv
package stall_stats_pkg;

    localparam int HIST_BINS  = 16;
    localparam int BIN_W      = $clog2(HIST_BINS);
    localparam int N_CAUSES   = 2;
    localparam int TOT_BASE   = N_CAUSES * HIST_BINS;
    localparam int RD_ADDR_W  = $clog2(TOT_BASE + N_CAUSES);

    typedef enum logic {
        CAUSE_DEP = 1'b0,
        CAUSE_MEM = 1'b1
    } stall_cause_e;

    typedef struct packed {
        logic             valid;
        stall_cause_e     cause;
        logic [BIN_W-1:0] bin;
    } episode_evt_t;

endpackage

// File: rtl/stall_episode_tracker.sv
module stall_episode_tracker
    import stall_stats_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         stall_i,
    input  stall_cause_e cause_i,
    output episode_evt_t evt_o,
    output logic         cyc_valid_o,
    output stall_cause_e cyc_cause_o
);

    localparam logic [BIN_W-1:0] LEN_CAP = BIN_W'(HIST_BINS - 1);

    logic             active_q;
    stall_cause_e     cause_q;
    logic [BIN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            active_q <= 1'b0;
            cause_q  <= CAUSE_DEP;
            len_q    <= '0;
        end else if (stall_i) begin
            if (!active_q) begin
                active_q <= 1'b1;
                cause_q  <= cause_i;
                len_q    <= BIN_W'(1);
            end else if (len_q != LEN_CAP) begin
                len_q <= len_q + BIN_W'(1);
            end
        end else begin
            active_q <= 1'b0;
            len_q    <= '0;
        end
    end

    always_comb begin
        evt_o.valid = active_q && !stall_i && !clear_i;
        evt_o.cause = cause_q;
        evt_o.bin   = len_q;
        cyc_valid_o = stall_i && !clear_i;
        cyc_cause_o = active_q ? cause_q : cause_i;
    end

    AST_ACTIVE_HAS_LENGTH: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (len_q != '0)); // R2

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
        (active_q && stall_i && !clear_i) |=> (cause_q == $past(cause_q))); // R4

    AST_EVENT_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
        evt_o.valid |-> $past(stall_i)); // R2

endmodule

// File: rtl/stall_counter_bank.sv
module stall_counter_bank
    import stall_stats_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  clear_i,
    input  episode_evt_t                          evt_i,
    input  logic                                  cyc_valid_i,
    input  stall_cause_e                          cyc_cause_i,
    output logic [TOT_BASE-1:0][CNT_W-1:0]        hist_o,
    output logic [N_CAUSES-1:0][CNT_W-1:0]        tot_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar c = 0; c < N_CAUSES; c++) begin : g_cause
        for (genvar b = 0; b < HIST_BINS; b++) begin : g_bin
            logic hit;
            assign hit = evt_i.valid && (evt_i.cause == stall_cause_e'(c))
                         && (evt_i.bin == BIN_W'(b));
            always_ff @(posedge clk) begin
                if (rst || clear_i)
                    hist_o[c*HIST_BINS+b] <= '0;
                else if (hit && hist_o[c*HIST_BINS+b] != CNT_MAX)
                    hist_o[c*HIST_BINS+b] <= hist_o[c*HIST_BINS+b] + CNT_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clear_i)
                tot_o[c] <= '0;
            else if (cyc_valid_i && cyc_cause_i == stall_cause_e'(c) && tot_o[c] != CNT_MAX)
                tot_o[c] <= tot_o[c] + CNT_W'(1);
        end

        AST_NO_WRAP_TOTAL: assert property (@(posedge clk) disable iff (rst)
            !clear_i |=> (tot_o[c] >= $past(tot_o[c]))); // R7

        AST_CLEAR_EMPTIES_TOTAL: assert property (@(posedge clk) disable iff (rst)
            clear_i |=> (tot_o[c] == '0)); // R8

        AST_BIN_ZERO_UNUSED: assert property (@(posedge clk) disable iff (rst)
            !clear_i |=> (hist_o[c*HIST_BINS] == '0)); // R3
    end

endmodule

// File: rtl/stall_stats.sv
module stall_stats
    import stall_stats_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 stall_i,
    input  logic                 stall_mem_i,
    input  logic [RD_ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]     rd_data_o
);

    episode_evt_t                   evt;
    logic                           cyc_valid;
    stall_cause_e                   cyc_cause;
    logic [TOT_BASE-1:0][CNT_W-1:0] hist;
    logic [N_CAUSES-1:0][CNT_W-1:0] tot;

    stall_episode_tracker u_tracker (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear_i),
        .stall_i    (stall_i),
        .cause_i    (stall_cause_e'(stall_mem_i)),
        .evt_o      (evt),
        .cyc_valid_o(cyc_valid),
        .cyc_cause_o(cyc_cause)
    );

    stall_counter_bank #(.CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear_i),
        .evt_i      (evt),
        .cyc_valid_i(cyc_valid),
        .cyc_cause_i(cyc_cause),
        .hist_o     (hist),
        .tot_o      (tot)
    );

    always_comb begin
        rd_data_o = '0;
        if (int'(rd_addr_i) < TOT_BASE)
            rd_data_o = hist[rd_addr_i[BIN_W:0]];
        else if (int'(rd_addr_i) == TOT_BASE)
            rd_data_o = tot[0];
        else if (int'(rd_addr_i) == TOT_BASE + 1)
            rd_data_o = tot[1];
    end

    AST_STALL_REACHES_TOTAL: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !clear_i && tot[0] != '1 && tot[1] != '1)
        |=> (tot[0] + tot[1] != $past(tot[0] + tot[1]))); // R5

endmodule

// File: tb/stall_stats_bench.sv
`timescale 1ns/1ps
module stall_stats_bench;

    localparam int CW  = 8;
    localparam int MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clear_i = 1'b0;
    logic          stall_i = 1'b0;
    logic          stall_mem_i = 1'b0;
    logic [5:0]    rd_addr_i = '0;
    logic [CW-1:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_hist[2][16];
    int m_tot[2];
    bit m_active;
    int m_len;
    int m_cause;

    always #2.5 clk = ~clk;

    stall_stats #(.CNT_W(CW)) u_stall_stats (
        .clk(clk), .rst(rst), .clear_i(clear_i), .stall_i(stall_i),
        .stall_mem_i(stall_mem_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    function automatic int sat(int v);
        return (v >= MAX) ? MAX : v + 1;
    endfunction

    function automatic int expect_at(int a);
        if (a < 32) return m_hist[a / 16][a % 16];
        if (a == 32) return m_tot[0];
        if (a == 33) return m_tot[1];
        return 0;
    endfunction

    task automatic model_zero();
        for (int c = 0; c < 2; c++) begin
            m_tot[c] = 0;
            for (int b = 0; b < 16; b++) m_hist[c][b] = 0;
        end
        m_active = 0;
        m_len = 0;
        m_cause = 0;
    endtask

    task automatic model_step(bit s, bit c, bit cl);
        if (cl) begin
            model_zero();
        end else if (s) begin
            if (!m_active) begin
                m_active = 1;
                m_cause = c;
                m_len = 1;
            end else begin
                m_len++;
            end
            m_tot[m_cause] = sat(m_tot[m_cause]);
        end else if (m_active) begin
            m_hist[m_cause][(m_len > 15) ? 15 : m_len] =
                sat(m_hist[m_cause][(m_len > 15) ? 15 : m_len]);
            m_active = 0;
        end
    endtask

    task automatic sweep();
        for (int a = 0; a < 36; a++) begin
            rd_addr_i = 6'(a);
            #0.05;
            checks++;
            if (int'(rd_data_o) != expect_at(a)) begin
                failures++;
                $display("FAIL %s addr=%0d actual=%0d expected=%0d",
                         (a > 33) ? "R9" : cur_req, a, rd_data_o, expect_at(a));
            end
        end
    endtask

    task automatic cyc(bit s, bit c, bit cl);
        stall_i = s;
        stall_mem_i = c;
        clear_i = cl;
        @(posedge clk);
        model_step(s, c, cl);
        @(negedge clk);
        sweep();
    endtask

    task automatic episode(int len, bit c);
        for (int i = 0; i < len; i++) cyc(1'b1, c, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_zero();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        sweep();

        cur_req = "R2";
        episode(2, 1'b0);
        episode(1, 1'b0);
        cur_req = "R6";
        episode(10, 1'b1);
        episode(2, 1'b1);
        cur_req = "R4";
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        cur_req = "R3";
        episode(14, 1'b0);
        episode(15, 1'b0);
        episode(20, 1'b1);
        cur_req = "R5";
        episode(3, 1'b0);
        episode(4, 1'b1);

        cur_req = "R8";
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        episode(5, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);

        cur_req = "R7";
        episode(300, 1'b0);
        for (int i = 0; i < 260; i++) episode(1, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule